// File: doc/BRIEF.md
# Panel Register Command Sequencer

This block is a transmit-only SPI master that programs the control registers of a small TFT panel. A register write is two separate 24-bit transactions. The first, an index transaction, names the register. The second, a data transaction, carries a 16-bit value. Chip select is released between the two transactions.

A small sequencer turns three requests into fixed lists of register writes:
- **Power up:** turn the panel on, then program the output-control register.
- **Resume:** program the output-control register, then turn the panel on.
- **Power down:** shut the panel down.

The output-control value comes from a fixed default word with four mode positions cleared. The caller's 4-bit mode field (flips, colour order, inversion) is then merged into those positions. The mode is captured at the moment a request is accepted.

The serial clock is the system clock divided by a parameter. The link uses SPI mode 0: the clock idles low, data is set up while the clock is low, it is sampled on the rising edge, and the most significant bit goes first. `busy` covers the whole of a sequence, and `done` marks its end.

Top module: `panel_cmd_seq`

## Requirements
- R1: Every index transaction shifts out the 24-bit word {0x74, 0x00, register number}, most significant bit first.
- R2: Every data transaction shifts out the 24-bit word {0x76, value[15:8], value[7:0]}, most significant bit first.
- R3: A power-up request produces four transactions: index 0x11, data 0x0000, index 0x01, data = output-control value.
- R4: A resume request produces four transactions: index 0x01, data = output-control value, index 0x11, data 0x0000.
- R5: A power-down request produces exactly two transactions: index 0x11, data 0x0001.
- R6: The output-control value is 0x00EF OR'd with mode bits at these positions:
  - mode[0] (left/right flip) at bit 14
  - mode[1] (top/bottom flip) at bit 9
  - mode[2] (BGR order) at bit 11
  - mode[3] (inverted) at bit 13

  This equals 0x2AEF with bits 14, 13, 11 and 9 cleared, then the mode bits merged in.
- R7: Chip select (active low) stays low for exactly 24 rising SCLK edges per transaction and goes high between transactions. SCLK is low whenever chip select is high.
- R8: When several requests arrive in the same cycle, power-down wins over power-up, and power-up wins over resume.
- R9: Requests that arrive while `busy` is high are ignored. They add no transaction.
- R10: `busy` is high from the cycle after a request is accepted until the sequence ends. `done` is high for exactly one cycle, in which `busy` is already low.
- R11: After reset, chip select is high, SCLK is low, and `busy` and `done` are low.
- R12: The mode field is sampled when the request is accepted. Changing it during a sequence does not change the value sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_up | input | 1 | Request the power-up sequence |
| req_down | input | 1 | Request the power-down sequence |
| req_resume | input | 1 | Request the resume sequence |
| mode | input | 4 | Orientation and colour-order mode bits |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Power-up and resume are each run for all sixteen mode values. Each serial frame is decoded from the pins and compared with words computed from the register numbers and bit positions. This separates a wrong bit mapping in the output-control value from a wrong write order between the two sequences.

Power-down is run with two different mode values. This shows that its single write ignores the mode and stops after two frames.

Simultaneous requests check the priority order. Requests and mode changes injected mid-sequence must leave the frame list exactly as the accepted request defined it.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

    localparam int FRAME_BITS = 24;

    localparam logic [7:0]  PFX_INDEX   = 8'h74;
    localparam logic [7:0]  PFX_DATA    = 8'h76;
    localparam logic [7:0]  REG_POWER   = 8'h11;
    localparam logic [7:0]  REG_OUTCTL  = 8'h01;
    localparam logic [15:0] OUTCTL_BASE = 16'h2AEF;

    // bit positions of the four mode fields inside the output-control word
    localparam int POS_FLIP_LR = 14;
    localparam int POS_FLIP_TB = 9;
    localparam int POS_BGR     = 11;
    localparam int POS_INVERT  = 13;

    typedef enum logic [1:0] {
        SEQ_UP     = 2'd0,
        SEQ_DOWN   = 2'd1,
        SEQ_RESUME = 2'd2
    } seq_e;

    function automatic logic [15:0] outctl_value(input logic [3:0] m);
        logic [15:0] mask;
        logic [15:0] bits;
        mask = (16'h1 << POS_FLIP_LR) | (16'h1 << POS_FLIP_TB)
             | (16'h1 << POS_BGR)     | (16'h1 << POS_INVERT);
        bits = (16'(m[0]) << POS_FLIP_LR) | (16'(m[1]) << POS_FLIP_TB)
             | (16'(m[2]) << POS_BGR)     | (16'(m[3]) << POS_INVERT);
        return (OUTCTL_BASE & ~mask) | bits;
    endfunction

endpackage

// File: rtl/panel_step_gen.sv
module panel_step_gen
    import panel_cmd_pkg::*;
(
    input  seq_e                  seq,
    input  logic [1:0]            step,
    input  logic [3:0]            mode,
    output logic [FRAME_BITS-1:0] word,
    output logic                  last
);
    logic        write_sel;
    logic        is_power;
    logic [7:0]  reg_num;
    logic [15:0] value;

    always_comb begin
        write_sel = step[1];
        // resume reverses the order of the two writes
        is_power  = (seq == SEQ_RESUME) ? write_sel : !write_sel;
        reg_num   = is_power ? REG_POWER : REG_OUTCTL;
        value     = is_power ? {15'd0, (seq == SEQ_DOWN)} : outctl_value(mode);
        word      = step[0] ? {PFX_DATA, value} : {PFX_INDEX, 8'h00, reg_num};
        last      = (step == 2'd3) || ((seq == SEQ_DOWN) && (step == 2'd1));
    end

endmodule

// File: rtl/panel_spi_tx.sv
module panel_spi_tx #(
    parameter int WIDTH      = 24,
    parameter int SCLK_HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] data,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             xfer_done
);
    localparam int DIV_W = $clog2(SCLK_HALF + 1);
    localparam int BIT_W = $clog2(WIDTH);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic             cs_n;
        logic [WIDTH-1:0] shreg;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bitn;
        logic             done;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.cs_n   = 1'b0;
                s_d.sclk   = 1'b0;
                s_d.shreg  = data;
                s_d.div    = '0;
                s_d.bitn   = '0;
            end
        end else if (s_q.div == DIV_W'(SCLK_HALF - 1)) begin
            s_d.div = '0;
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
            end else begin
                s_d.sclk = 1'b0;
                if (s_q.bitn == BIT_W'(WIDTH - 1)) begin
                    s_d.active = 1'b0;
                    s_d.cs_n   = 1'b1;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.bitn  = s_q.bitn + 1'b1;
                    s_d.shreg = {s_q.shreg[WIDTH-2:0], 1'b0};
                end
            end
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cs_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk      = s_q.sclk;
    assign mosi      = s_q.active & s_q.shreg[WIDTH-1];
    assign cs_n      = s_q.cs_n;
    assign xfer_done = s_q.done;

endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
    import panel_cmd_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int CS_GAP    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_up,
    input  logic       req_down,
    input  logic       req_resume,
    input  logic [3:0] mode,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       busy,
    output logic       done
);
    localparam int GAP_W = $clog2(CS_GAP + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_GAP    = 2'd3
    } ctl_e;

    typedef struct packed {
        ctl_e             st;
        seq_e             seq;
        logic [3:0]       mode;
        logic [1:0]       step;
        logic [GAP_W-1:0] gap;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [FRAME_BITS-1:0] word;
    logic                  last;
    logic                  xfer_done;
    logic                  start;

    panel_step_gen u_step (
        .seq  (c_q.seq),
        .step (c_q.step),
        .mode (c_q.mode),
        .word (word),
        .last (last)
    );

    assign start = (c_q.st == ST_LAUNCH);

    panel_spi_tx #(
        .WIDTH     (FRAME_BITS),
        .SCLK_HALF (SCLK_HALF)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .data      (word),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .xfer_done (xfer_done)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_down || req_up || req_resume) begin
                    c_d.st   = ST_LAUNCH;
                    c_d.step = '0;
                    c_d.mode = mode;
                    if (req_down)    c_d.seq = SEQ_DOWN;
                    else if (req_up) c_d.seq = SEQ_UP;
                    else             c_d.seq = SEQ_RESUME;
                end
            end
            ST_LAUNCH: c_d.st = ST_WAIT;
            ST_WAIT: begin
                if (xfer_done) begin
                    if (last) begin
                        c_d.st   = ST_IDLE;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st   = ST_GAP;
                        c_d.step = c_q.step + 1'b1;
                        c_d.gap  = '0;
                    end
                end
            end
            ST_GAP: begin
                if (c_q.gap == GAP_W'(CS_GAP - 1)) c_d.st = ST_LAUNCH;
                else                               c_d.gap = c_q.gap + 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= ST_IDLE;
            c_q.seq <= SEQ_UP;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.st != ST_IDLE);
    assign done = c_q.done;

endmodule

// File: rtl/panel_cmd_seq_chk.sv
module panel_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_up,
    input logic       req_down,
    input logic       req_resume,
    input logic       sclk,
    input logic       cs_n,
    input logic       busy,
    input logic       done
);
    // R7
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R7
    cs_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_up || req_down || req_resume));

endmodule

bind panel_cmd_seq panel_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_up     (req_up),
    .req_down   (req_down),
    .req_resume (req_resume),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/panel_cmd_seq_tb.sv
`timescale 1ns/1ps
module panel_cmd_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_up = 1'b0, req_down = 1'b0, req_resume = 1'b0;
    logic [3:0] mode = 4'd0;
    logic       sclk, mosi, cs_n, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    panel_cmd_seq #(.SCLK_HALF(2), .CS_GAP(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_down(req_down),
        .req_resume(req_resume), .mode(mode), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy), .done(done)
    );

    // serial monitor decoding frames from the pins
    logic [23:0] sh = '0;
    int          nb = 0;
    logic [23:0] fr_word [0:7];
    int          fr_bits [0:7];
    int          fr_cnt = 0;
    int          sclk_bad = 0;

    always @(negedge cs_n) begin sh = '0; nb = 0; end
    always @(posedge sclk) if (!cs_n) begin sh = {sh[22:0], mosi}; nb++; end
    always @(posedge cs_n) begin
        if (nb != 0) begin
            if (fr_cnt < 8) begin fr_word[fr_cnt] = sh; fr_bits[fr_cnt] = nb; end
            fr_cnt++;
            nb = 0;
        end
    end
    always @(negedge clk) if (rst_n && cs_n && sclk) sclk_bad++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_outctl(input logic [3:0] m);
        return 16'h00EF | (16'(m[0]) << 14) | (16'(m[1]) << 9)
                        | (16'(m[2]) << 11) | (16'(m[3]) << 13);
    endfunction

    // kind: 0 power-up, 1 power-down, 2 resume
    function automatic logic [23:0] exp_frame(input int kind, input int i, input logic [3:0] m);
        logic [7:0]  r;
        logic [15:0] v;
        logic        pwr;
        pwr = (kind == 2) ? (i >= 2) : (i < 2);
        r   = pwr ? 8'h11 : 8'h01;
        v   = pwr ? ((kind == 1) ? 16'h0001 : 16'h0000) : exp_outctl(m);
        return (i % 2 == 0) ? {8'h74, 8'h00, r} : {8'h76, v};
    endfunction

    task automatic run_seq(input bit up, input bit dn, input bit rs,
                           input logic [3:0] m, input int kind, input bit disturb);
        int    guard;
        int    nexp;
        string tag;
        @(negedge clk);
        fr_cnt = 0;
        mode = m; req_up = up; req_down = dn; req_resume = rs;
        @(negedge clk);
        req_up = 0; req_down = 0; req_resume = 0;
        chk("R10 busy after accept", 32'(busy), 32'd1);
        if (disturb) begin
            repeat (5) @(negedge clk);
            mode = ~m; req_up = 1; req_down = 1; req_resume = 1;   // R9 R12
            @(negedge clk);
            req_up = 0; req_down = 0; req_resume = 0;
        end
        guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        chk("R10 done seen", 32'(done), 32'd1);
        chk("R10 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
        repeat (40) @(negedge clk);
        nexp = (kind == 1) ? 2 : 4;
        tag  = (kind == 0) ? "R3" : (kind == 1) ? "R5" : "R4";
        chk({tag, " R9 frame count"}, 32'(fr_cnt), 32'(nexp));
        chk("R9 idle after sequence", 32'(busy), 32'd0);
        for (int i = 0; i < nexp && i < fr_cnt && i < 8; i++) begin
            chk("R7 bits per frame", 32'(fr_bits[i]), 32'd24);
            if (i % 2 == 0) chk("R1 index prefix", 32'(fr_word[i][23:8]), 32'h7400);
            else            chk("R2 data prefix", 32'(fr_word[i][23:16]), 32'h76);
            if (disturb)
                chk({tag, " R12 frame"}, 32'(fr_word[i]), 32'(exp_frame(kind, i, m)));
            else if (fr_word[i][23:16] == 8'h76 && kind != 1 &&
                     ((kind == 0 && i == 3) || (kind == 2 && i == 1)))
                chk({tag, " R6 outctl frame"}, 32'(fr_word[i]), 32'(exp_frame(kind, i, m)));
            else
                chk({tag, " frame"}, 32'(fr_word[i]), 32'(exp_frame(kind, i, m)));
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 cs_n", 32'(cs_n), 32'd1);
        chk("R11 sclk", 32'(sclk), 32'd0);
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 done", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int m = 0; m < 16; m++) begin
            run_seq(1, 0, 0, 4'(m), 0, 0);   // R3 R6
            run_seq(0, 0, 1, 4'(m), 2, 0);   // R4 R6
        end
        run_seq(0, 1, 0, 4'h0, 1, 0);        // R5
        run_seq(0, 1, 0, 4'hA, 1, 0);        // R5 mode has no effect
        run_seq(1, 1, 1, 4'h3, 1, 0);        // R8 down wins
        run_seq(1, 0, 1, 4'h6, 0, 0);        // R8 up over resume
        run_seq(1, 0, 0, 4'h9, 0, 1);        // R9 R12
        run_seq(0, 0, 1, 4'h5, 2, 1);        // R9 R12
        chk("R7 sclk low while deselected", 32'(sclk_bad), 32'd0);
        summary();
        $finish;
    end

endmodule